// File: doc/BRIEF.md
# Single-Cycle MIPS-Subset Processor Core

This block is a processor core that finishes one instruction in every clock cycle. It fetches a 32-bit instruction word from a 32-word instruction store. It decodes the instruction, reads two operands from a 32-entry register file and computes a result in the ALU. In the same cycle it either accesses an 8-word data store or writes a register, and it chooses the next program counter. It supports these instructions:

- R-format add, subtract, AND, OR and set-on-less-than.
- Load word and store word.
- Branch-if-equal.
- An absolute jump.
- Two logical-immediate instructions, OR-immediate and AND-immediate.

The datapath width `DW` is a parameter. Registers, the ALU and the data store all take that width, and the core works at 32 bits and at narrower widths such as 20, 24 or 28. Instructions and the program counter stay 32 bits wide at every width.

The instruction store is filled through a load port, normally while reset is held. For observation the core brings out four values: the program counter, the opcode of the current instruction, the ALU result and the word read from the data store.

The decoder classifies each opcode into one instruction class: RTYPE, LOAD, STORE, BRANCH, JUMP, ORIMM, ANDIMM or ILLEGAL. Control flow is described by three named transitions of the program counter, always taken on the next clock edge:

- SEQ goes to PC+4.
- TAKEN goes to the branch target.
- JUMP goes to the jump target.

Reset forces the program counter to zero.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, on each clock edge the PC becomes 0, every register becomes 0 and the data-store words 0..7 take the values 0x5, 0xA, 0x55, 0xAA, 0x5555, 0x8888, 0x550000 and 0x4444, each truncated to DW bits.
- R2: Opcode 000000 is R-format. The destination is rd, instruction bits 15:11; the sources are rs (bits 25:21) and rt (bits 20:16). The funct field in bits 5:0 selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-on-less-than. Set-on-less-than is an unsigned comparison that writes 1 or 0.
- R3: Register 0 always reads as zero, and a write to it leaves it unchanged.
- R4: Load word (100011) and store word (101011) use the address rs + sign-extended imm[15:0], and only its low 3 bits index the data store. The load writes rt with the word that is read combinationally. The store writes the value of rt on the clock edge. The ALU output shows the address.
- R5: Branch-if-equal (000100) makes the next PC PC+4+(sign-extended imm<<2) when rs equals rt, and PC+4 otherwise. The ALU output shows rs-rt. A branch writes nothing.
- R6: Jump (000010) makes the next PC equal to {PC+4[31:28], instr[25:0], 2'b00}. A jump writes no register and no memory.
- R7: OR-immediate (001101) and AND-immediate (001100) zero-extend imm[15:0] and write rs OR imm or rs AND imm into rt. Immediate bit 15 never extends into the upper bits.
- R8: Every instruction that is not a taken branch or a jump advances the PC by 4. The instruction is read from store word PC[6:2], and that store is written word by word through the load port.
- R9: At a reduced width DW, every register, ALU result and data-store value is held modulo 2^DW, and sign extension fills bit 15 of the immediate up to bit DW-1.
- R10: Any other opcode writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Writes `load_data` into the instruction store |
| load_addr | input | 5 | Word index for the instruction-store write |
| load_data | input | 32 | Instruction word to store |
| pc_o | output | 32 | Current program counter |
| opcode_o | output | 6 | Opcode of the current instruction |
| alu_res_o | output | DW | ALU result of the current instruction |
| dmem_rdata_o | output | DW | Data-store word at the current ALU address |

## Verification
The checker watches control flow on every cycle:

- Reset returns the PC to zero, and sequential instructions advance it by four.
- A jump lands on its target field.
- A branch lands on PC+4 when the operands differ, and on the scaled offset target when they are equal.
- Register 0 always reads as zero.
- OR-immediate never carries immediate bit 15 into the upper result bits.

Register contents, store-then-load ordering, the data-store reset values and truncation at a reduced width can only be shown by the bench's programs. The bench runs a directed load/add/store/reload, branch, jump and immediate program and several random programs. It does this on a 32-bit core and a 20-bit core at once, and compares both against an instruction-level model.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;

    // instruction classes produced by the decoder
    typedef enum logic [2:0] {
        CLS_RTYPE, CLS_LOAD, CLS_STORE, CLS_BRANCH,
        CLS_JUMP, CLS_ORIMM, CLS_ANDIMM, CLS_ILLEGAL
    } instr_cls_e;

    // operation request from decoder to ALU control
    typedef enum logic [2:0] {
        AOP_ADD, AOP_SUB, AOP_FUNCT, AOP_OR, AOP_AND
    } alu_op_e;

    typedef enum logic [3:0] {
        ACT_AND  = 4'b0000,
        ACT_OR   = 4'b0001,
        ACT_ADD  = 4'b0010,
        ACT_SUB  = 4'b0110,
        ACT_SLT  = 4'b0111,
        ACT_PASS = 4'b1111
    } alu_ctl_e;

    typedef enum logic [1:0] {
        PCN_SEQ, PCN_TAKEN, PCN_JUMP
    } pc_next_e;

    typedef struct packed {
        logic    dst_rd;
        logic    use_imm;
        logic    zext_imm;
        logic    wb_mem;
        logic    reg_we;
        logic    mem_we;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [31:0] dstore_init(input int idx);
        case (idx)
            0:       return 32'h0000_0005;
            1:       return 32'h0000_000A;
            2:       return 32'h0000_0055;
            3:       return 32'h0000_00AA;
            4:       return 32'h0000_5555;
            5:       return 32'h0000_8888;
            6:       return 32'h0055_0000;
            7:       return 32'h0000_4444;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output instr_cls_e cls,
    output ctrl_t      ctrl
);

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: cls = CLS_RTYPE;
            OPC_LW:    cls = CLS_LOAD;
            OPC_SW:    cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BRANCH;
            OPC_JUMP:  cls = CLS_JUMP;
            OPC_ORI:   cls = CLS_ORIMM;
            OPC_ANDI:  cls = CLS_ANDIMM;
            default:   cls = CLS_ILLEGAL;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (cls)
            CLS_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = AOP_FUNCT;
            end
            CLS_LOAD: begin
                ctrl.use_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.alu_op  = AOP_ADD;
            end
            CLS_STORE: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
                ctrl.alu_op  = AOP_ADD;
            end
            CLS_BRANCH: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            CLS_JUMP: begin
                ctrl.jump = 1'b1;
            end
            CLS_ORIMM: begin
                ctrl.use_imm  = 1'b1;
                ctrl.zext_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.alu_op   = AOP_OR;
            end
            CLS_ANDIMM: begin
                ctrl.use_imm  = 1'b1;
                ctrl.zext_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.alu_op   = AOP_AND;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e          op,
    input  logic [5:0]       funct,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output logic [DW-1:0]    y,
    output logic             zero
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    alu_ctl_e ctl;

    always_comb begin
        unique case (op)
            AOP_ADD: ctl = ACT_ADD;
            AOP_SUB: ctl = ACT_SUB;
            AOP_OR:  ctl = ACT_OR;
            AOP_AND: ctl = ACT_AND;
            AOP_FUNCT: begin
                unique case (funct)
                    6'b100000: ctl = ACT_ADD;
                    6'b100010: ctl = ACT_SUB;
                    6'b100100: ctl = ACT_AND;
                    6'b100101: ctl = ACT_OR;
                    6'b101010: ctl = ACT_SLT;
                    default:   ctl = ACT_PASS;
                endcase
            end
            default: ctl = ACT_PASS;
        endcase
    end

    always_comb begin
        unique case (ctl)
            ACT_AND:  y = a & b;
            ACT_OR:   y = a | b;
            ACT_ADD:  y = a + b;
            ACT_SUB:  y = a - b;
            ACT_SLT:  y = (a < b) ? ONE : '0;
            default:  y = a;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREG)-1:0]  ra_a,
    input  logic [$clog2(NREG)-1:0]  ra_b,
    input  logic [$clog2(NREG)-1:0]  wa,
    input  logic [DW-1:0]            wd,
    input  logic                     we,
    output logic [DW-1:0]            rd_a,
    output logic [DW-1:0]            rd_b
);

    logic [DW-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wa == g))
                regs[g] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/sc_dstore.sv
module sc_dstore
    import sc_core_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(DEPTH)-1:0]  addr,
    input  logic                      we,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata
);

    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [31:0] INIT = dstore_init(g);
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= INIT[DW-1:0];
            else if (we && (addr == g))
                words[g] <= wdata;
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int DW     = 32,
    parameter int IWORDS = 32,
    parameter int DWORDS = 8,
    parameter int NREG   = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_en,
    input  logic [$clog2(IWORDS)-1:0]  load_addr,
    input  logic [31:0]                load_data,
    output logic [31:0]                pc_o,
    output logic [5:0]                 opcode_o,
    output logic [DW-1:0]              alu_res_o,
    output logic [DW-1:0]              dmem_rdata_o
);

    localparam int IA = $clog2(IWORDS);
    localparam int DA = $clog2(DWORDS);
    localparam int RA = $clog2(NREG);

    logic [31:0]   pc;
    logic [31:0]   pc_plus4;
    logic [31:0]   pc_next;
    logic [31:0]   br_off;
    logic [31:0]   instr;
    logic [31:0]   istore [IWORDS];
    instr_cls_e    cls;
    ctrl_t         ctrl;
    pc_next_e      pc_sel;
    logic [DW-1:0] rd_a;
    logic [DW-1:0] rd_b;
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] alu_b;
    logic [DW-1:0] alu_y;
    logic          alu_zero;
    logic [DW-1:0] mem_rd;
    logic [DW-1:0] wb_val;
    logic [RA-1:0] wb_addr;

    // instruction store, written only through the load port
    always_ff @(posedge clk) begin
        if (load_en)
            istore[load_addr] <= load_data;
    end

    assign instr = istore[pc[IA+1:2]];

    sc_decoder u_dec (
        .opcode (instr[31:26]),
        .cls    (cls),
        .ctrl   (ctrl)
    );

    sc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .wa   (wb_addr),
        .wd   (wb_val),
        .we   (ctrl.reg_we),
        .rd_a (rd_a),
        .rd_b (rd_b)
    );

    assign imm_ext = ctrl.zext_imm ? {{(DW-16){1'b0}}, instr[15:0]}
                                   : {{(DW-16){instr[15]}}, instr[15:0]};
    assign alu_b   = ctrl.use_imm ? imm_ext : rd_b;

    sc_alu #(.DW(DW)) u_alu (
        .op    (ctrl.alu_op),
        .funct (instr[5:0]),
        .a     (rd_a),
        .b     (alu_b),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    sc_dstore #(.DW(DW), .DEPTH(DWORDS)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .addr  (alu_y[DA-1:0]),
        .we    (ctrl.mem_we),
        .wdata (rd_b),
        .rdata (mem_rd)
    );

    assign wb_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_val  = ctrl.wb_mem ? mem_rd : alu_y;

    // next-PC transition selection
    always_comb begin
        if (ctrl.jump)
            pc_sel = PCN_JUMP;
        else if (ctrl.branch && alu_zero)
            pc_sel = PCN_TAKEN;
        else
            pc_sel = PCN_SEQ;
    end

    assign pc_plus4 = pc + 32'd4;
    assign br_off   = {{14{instr[15]}}, instr[15:0], 2'b00};

    always_comb begin
        unique case (pc_sel)
            PCN_JUMP:  pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
            PCN_TAKEN: pc_next = pc_plus4 + br_off;
            default:   pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else
            pc <= pc_next;
    end

    always_comb begin
        pc_o         = pc;
        opcode_o     = instr[31:26];
        alu_res_o    = alu_y;
        dmem_rdata_o = mem_rd;
    end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [31:0]   pc_o,
    input logic [5:0]    opcode_o,
    input logic [31:0]   instr,
    input logic [DW-1:0] rd_a,
    input logic [DW-1:0] rd_b,
    input logic [DW-1:0] alu_y
);

    // R1
    pc_reset_chk: assert property (@(posedge clk)
        rst |=> (pc_o == 32'd0));

    // R8
    pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode_o != OPC_BEQ && opcode_o != OPC_JUMP) |=> (pc_o == $past(pc_o) + 32'd4));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode_o == OPC_JUMP) |=> (pc_o[27:0] == {$past(instr[25:0]), 2'b00}));

    // R5
    beq_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode_o == OPC_BEQ && rd_a != rd_b) |=> (pc_o == $past(pc_o) + 32'd4));

    // R5
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode_o == OPC_BEQ && rd_a == rd_b) |=>
        (pc_o == $past(pc_o) + 32'd4 + $past({{14{instr[15]}}, instr[15:0], 2'b00})));

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rd_a == '0));

    // R7
    ori_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode_o == OPC_ORI) |-> (alu_y == (rd_a | {{(DW-16){1'b0}}, instr[15:0]})));

endmodule

bind sc_core sc_core_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pc_o     (pc_o),
    .opcode_o (opcode_o),
    .instr    (instr),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .alu_y    (alu_y)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    localparam int NDW = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [4:0]  load_addr = '0;
    logic [31:0] load_data = '0;

    logic [31:0]    pc0, pc1;
    logic [5:0]     op0, op1;
    logic [31:0]    alu0, rdat0;
    logic [NDW-1:0] alu1, rdat1;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sc_core #(.DW(32)) dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .pc_o(pc0), .opcode_o(op0),
        .alu_res_o(alu0), .dmem_rdata_o(rdat0)
    );

    sc_core #(.DW(NDW)) dut_n (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .pc_o(pc1), .opcode_o(op1),
        .alu_res_o(alu1), .dmem_rdata_o(rdat1)
    );

    // instruction-level model state, index 0 = 32-bit core, 1 = reduced core
    logic [31:0] prog [32];
    logic [31:0] m_reg [2][32];
    logic [31:0] m_mem [2][8];
    logic [31:0] m_pc  [2];

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'b000010, 26'(tgt)};
    endfunction

    function automatic logic [31:0] init_word(int i);
        case (i)
            0: return 32'h5;      1: return 32'hA;
            2: return 32'h55;     3: return 32'hAA;
            4: return 32'h5555;   5: return 32'h8888;
            6: return 32'h550000; default: return 32'h4444;
        endcase
    endfunction

    function automatic string tag_of(logic [5:0] op);
        case (op)
            6'b000000:            return "R2";
            6'b100011, 6'b101011: return "R4";
            6'b000100:            return "R5";
            6'b000010:            return "R6";
            6'b001101, 6'b001100: return "R7";
            default:              return "R10";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            logic [31:0] msk = (k == 0) ? 32'hFFFF_FFFF : 32'h000F_FFFF;
            for (int r = 0; r < 32; r++) m_reg[k][r] = '0;
            for (int w = 0; w < 8; w++)  m_mem[k][w] = init_word(w) & msk;
            m_pc[k] = '0;
        end
    endtask

    // compare one core against the model, then advance the model by one instruction
    task automatic step_k(int k);
        logic [31:0] msk = (k == 0) ? 32'hFFFF_FFFF : 32'h000F_FFFF;
        logic [31:0] ins = prog[m_pc[k][6:2]];
        logic [5:0]  op  = ins[31:26];
        int rs = int'(ins[25:21]);
        int rt = int'(ins[20:16]);
        int rd = int'(ins[15:11]);
        logic [31:0] a  = m_reg[k][rs];
        logic [31:0] b  = m_reg[k][rt];
        logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
        logic [31:0] zx = {16'h0, ins[15:0]};
        logic [31:0] pc4 = m_pc[k] + 32'd4;
        logic [31:0] nxt = pc4;
        logic [31:0] alu = '0;
        logic [31:0] wv  = '0;
        logic        wr = 1'b0, st = 1'b0, c_alu = 1'b1, c_mem = 1'b0;
        int          wa = 0;
        string       tg = tag_of(op);
        logic [31:0] a_pc  = (k == 0) ? pc0 : pc1;
        logic [31:0] a_alu = (k == 0) ? alu0 : 32'(alu1);
        logic [31:0] a_rd  = (k == 0) ? rdat0 : 32'(rdat1);
        if (k == 1) tg = {"R9/", tg};
        case (op)
            6'b000000: begin
                case (ins[5:0])
                    6'b100000: alu = a + b;
                    6'b100010: alu = a - b;
                    6'b100100: alu = a & b;
                    6'b100101: alu = a | b;
                    6'b101010: alu = (a < b) ? 32'd1 : 32'd0;
                    default:   alu = a;
                endcase
                wr = 1'b1; wa = rd;
            end
            6'b100011: begin alu = a + sx; wr = 1'b1; wa = rt; c_mem = 1'b1; end
            6'b101011: begin alu = a + sx; st = 1'b1; c_mem = 1'b1; end
            6'b000100: begin
                alu = a - b;
                if ((alu & msk) == 0) nxt = pc4 + (sx << 2);
            end
            6'b000010: begin c_alu = 1'b0; nxt = {pc4[31:28], ins[25:0], 2'b00}; end
            6'b001101: begin alu = a | zx; wr = 1'b1; wa = rt; end
            6'b001100: begin alu = a & zx; wr = 1'b1; wa = rt; end
            default:   c_alu = 1'b0;
        endcase
        alu = alu & msk;
        if (op == 6'b100011) wv = m_mem[k][alu[2:0]];
        else                 wv = alu;
        chk({tg, " pc"}, a_pc, m_pc[k]);
        if (c_alu) chk({tg, " alu"}, a_alu, alu);
        if (c_mem) chk({tg, " mem"}, a_rd, m_mem[k][alu[2:0]]);
        if (st) m_mem[k][alu[2:0]] = b;
        if (wr && wa != 0) m_reg[k][wa] = wv & msk;
        m_pc[k] = nxt;
    endtask

    // hold reset, load the program, check reset state, release and run
    task automatic run_prog(int cycles);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 32; i++) begin
            load_en = 1'b1; load_addr = 5'(i); load_data = prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        chk("R1 pc", pc0, 32'd0);
        chk("R1 R9 pc", pc1, 32'd0);
        model_reset();
        rst = 1'b0;
        #1;
        for (int c = 0; c < cycles; c++) begin
            step_k(0);
            step_k(1);
            @(negedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] rand_instr();
        int sel = int'($urandom % 10);
        int r1 = int'($urandom % 8), r2 = int'($urandom % 8), r3 = int'($urandom % 8);
        logic [5:0] fns [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        case (sel)
            0, 1, 2: return enc_r(r1, r2, r3, fns[$urandom % 5]);
            3:       return enc_i(6'b001101, r1, r2, 16'($urandom));
            4:       return enc_i(6'b001100, r1, r2, 16'($urandom));
            5:       return enc_i(6'b100011, r1, r2, 16'($urandom % 16));
            6:       return enc_i(6'b101011, r1, r2, 16'($urandom % 16));
            7:       return enc_i(6'b000100, r1, r2, 16'($urandom % 4));
            8:       return enc_j(int'($urandom % 32));
            default: return enc_i(6'b111111, r1, r2, 16'($urandom));
        endcase
    endfunction

    logic done = 1'b0;

    initial begin
        void'($urandom(32'd24681));
        // directed program: memory round trip, branches, jump, immediates
        for (int i = 0; i < 32; i++) prog[i] = enc_i(6'b000100, 0, 0, 16'hFFFF);
        prog[0]  = enc_i(6'b100011, 0, 1, 16'd3);        // R4 r1 <- mem3
        prog[1]  = enc_i(6'b100011, 0, 2, 16'd4);        // R4 r2 <- mem4
        prog[2]  = enc_r(1, 2, 3, 6'b100000);            // R2 add
        prog[3]  = enc_i(6'b101011, 0, 3, 16'd5);        // R4 store sum
        prog[4]  = enc_i(6'b100011, 0, 4, 16'd5);        // R4 reload
        prog[5]  = enc_i(6'b000100, 1, 2, 16'd5);        // R5 not taken
        prog[6]  = enc_i(6'b000100, 3, 4, 16'd1);        // R5 taken, skip 7
        prog[7]  = enc_i(6'b001101, 0, 5, 16'hFFFF);
        prog[8]  = enc_j(10);                            // R6 skip 9
        prog[9]  = enc_i(6'b001101, 0, 6, 16'd1);
        prog[10] = enc_i(6'b001101, 0, 7, 16'h8001);     // R7 zero extension
        prog[11] = enc_r(0, 1, 9, 6'b100010);            // negative value
        prog[12] = enc_i(6'b001100, 9, 8, 16'h8F0F);     // R7 andi
        prog[13] = enc_r(7, 0, 0, 6'b100000);            // R3 write to r0
        prog[14] = enc_r(0, 0, 10, 6'b100000);           // R3 r0 still zero
        prog[15] = enc_r(1, 2, 11, 6'b101010);
        prog[16] = enc_r(2, 1, 12, 6'b101010);
        prog[17] = enc_r(9, 7, 13, 6'b100100);
        prog[18] = enc_r(9, 7, 14, 6'b100101);
        prog[19] = enc_i(6'b111111, 0, 1, 16'h0007);     // R10 illegal
        prog[20] = enc_r(1, 0, 0, 6'b100101);            // observe r1
        prog[21] = enc_i(6'b100011, 9, 15, 16'h0007);    // R9 sign-extended address
        prog[22] = enc_i(6'b100011, 0, 16, 16'd6);       // R9 truncated init word
        run_prog(30);
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 31; i++) prog[i] = rand_instr();
            prog[31] = enc_i(6'b000100, 0, 0, 16'hFFFF);
            run_prog(48);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule